// File: doc/BRIEF.md
# Oscillator Settling Time Status

This block tells software how long a crystal oscillator has been running since it last started, so that a clock switch is only made once the oscillator has settled. A counter clocked by the oscillator itself counts edges from the moment oscillation is present. The elapsed time is shown as an 8-bit thermometer word. Each bit stands for one power-of-two threshold, and bits fill from the most significant end as time passes. A 3-bit select picks a settling limit. At that limit the counter halts, a done flag rises, and no threshold beyond the limit is ever reported.

The word is cleared on reset, on stop-mode entry, while the oscillator is disabled and while the oscillator has not yet started. A copy of the word is carried into the bus clock domain through a flop synchronizer for reading. Because the code only ever gains ones between clears, each bus-side sample is a valid thermometer value.

Top module: `osc_settle_status`

## Requirements
- R1: While `rst_n` is low (asynchronous), `status_osc`, `status_bus` and `settle_done` are 0. Reset takes effect without waiting for a clock edge.
- R2: Let N be the number of `osc_clk` rising edges with counting enabled since the last clear. Bit 7 of `status_osc` is 1 once N ≥ 2^(8−EXP_OFFSET), bit 6 once N ≥ 2^(9−EXP_OFFSET), bit 5 at 2^(10−EXP_OFFSET), bit 4 at 2^(11−EXP_OFFSET), bit 3 at 2^(13−EXP_OFFSET), bit 2 at 2^(15−EXP_OFFSET), bit 1 at 2^(17−EXP_OFFSET) and bit 0 at 2^(18−EXP_OFFSET). Each bit updates on the edge that completes its count. The word is always a thermometer code of the form 1…10…0.
- R3: Between clears, a bit of `status_osc` that is set stays set.
- R4: A cycle with `stop_enter` high clears the count, `status_osc` and `settle_done` on that edge. Counting restarts from zero on the next enabled edge.
- R5: While `osc_off` is 1, the count and status are held at zero. After release, the first edge counts as N = 1.
- R6: `limit_sel` codes 0 to 7 choose limits equal to the thresholds of status bits 7 down to 0. The count halts at the chosen limit, so status bits for longer thresholds stay 0.
- R7: `settle_done` rises on the edge where N reaches the selected limit. It stays high until the next clear, and it is 0 one edge earlier.
- R8: While `osc_started` is 0, nothing is counted and the status stays zero. The time before oscillation begins is therefore excluded.
- R9: `status_bus` follows `status_osc` through SYNC_STAGES `bus_clk` flops. Once `status_osc` is stable it equals it within SYNC_STAGES+1 bus cycles, and it is always a thermometer code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; counting domain |
| bus_clk | input | 1 | Bus clock for the read copy |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| stop_enter | input | 1 | Stop-mode entry pulse, osc_clk domain |
| osc_off | input | 1 | Oscillator disable; holds count at zero |
| osc_started | input | 1 | High once oscillator edges are present |
| limit_sel | input | 3 | Settling limit select, codes 0 to 7 |
| status_osc | output | 8 | Thermometer status, osc_clk domain |
| settle_done | output | 1 | High once the selected limit is reached |
| status_bus | output | 8 | Synchronized status for bus reads |

## Verification
A wrong count value shows up at the status port at the next threshold crossing. A bit then appears one edge early or late, so directed runs sample the word one edge before and exactly on each threshold. A wrong halt or limit decode sets a bit beyond the chosen limit, or leaves the done flag out of step, within a few edges after the limit. A missed clear leaves a nonzero word on the very edge after the clear condition. A broken synchronizer leaves the bus copy different from the oscillator-side word a few bus cycles after the word settles.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;
   localparam int unsigned TAPS    = 8;
   localparam int unsigned SEL_W   = $clog2(TAPS);
   localparam int unsigned EXP_TOP = 18;

   // Exponent of the threshold for tap index idx (tap 0 is the shortest)
   function automatic int unsigned tap_exp(input int unsigned idx);
      case (idx)
         0:       return 8;
         1:       return 9;
         2:       return 10;
         3:       return 11;
         4:       return 13;
         5:       return 15;
         6:       return 17;
         default: return 18;
      endcase
   endfunction
endpackage

// File: rtl/osc_settle_count.sv
module osc_settle_count
   import osc_settle_pkg::*;
#(
   parameter int unsigned EXP_OFFSET = 0,
   parameter int unsigned CNT_W      = EXP_TOP + 1 - EXP_OFFSET
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic [CNT_W-1:0] cnt_q,
   output logic             done_q
);
   logic [CNT_W-1:0] lim_tab [TAPS];
   logic [CNT_W-1:0] limit;

   for (genvar g = 0; g < TAPS; g++) begin : g_lim
      localparam int unsigned E = tap_exp(g) - EXP_OFFSET;
      assign lim_tab[g] = CNT_W'(1) << E;
   end

   assign limit = lim_tab[sel];

   always_comb begin
      if (clr)
         cnt_nxt = '0;
      else if (cnt_q < limit)
         cnt_nxt = cnt_q + CNT_W'(1);
      else
         cnt_nxt = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_nxt;
         done_q <= !clr && (cnt_nxt >= limit);
      end
   end

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0) && !done_q); // R4
   AST_CNT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && cnt_q >= limit) |=> $stable(cnt_q)); // R6
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !clr) |=> done_q); // R7
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && cnt_q < limit) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
endmodule

// File: rtl/osc_settle_thermo.sv
module osc_settle_thermo
   import osc_settle_pkg::*;
#(
   parameter int unsigned EXP_OFFSET = 0,
   parameter int unsigned CNT_W      = EXP_TOP + 1 - EXP_OFFSET
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] cnt_nxt,
   output logic [TAPS-1:0]  status_q
);
   logic [TAPS-1:0] status_d;

   // Reaching 2^E means some count bit at or above E is set
   for (genvar g = 0; g < TAPS; g++) begin : g_tap
      localparam int unsigned E = tap_exp(g) - EXP_OFFSET;
      assign status_d[TAPS-1-g] = |cnt_nxt[CNT_W-1:E];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status_q <= '0;
      else if (clr)
         status_q <= '0;
      else
         status_q <= status_d;
   end

   AST_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
      status_q == ~({TAPS{1'b1}} >> $countones(status_q))); // R2
   AST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((status_q & $past(status_q)) == $past(status_q))); // R3
   AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (status_q == '0)); // R4
endmodule

// File: rtl/osc_settle_sync.sv
module osc_settle_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];

   AST_BUS_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
      q == ~({W{1'b1}} >> $countones(q))); // R9
endmodule

// File: rtl/osc_settle_status.sv
module osc_settle_status
   import osc_settle_pkg::*;
#(
   parameter int unsigned EXP_OFFSET  = 0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             osc_clk,
   input  logic             bus_clk,
   input  logic             rst_n,
   input  logic             stop_enter,
   input  logic             osc_off,
   input  logic             osc_started,
   input  logic [SEL_W-1:0] limit_sel,
   output logic [TAPS-1:0]  status_osc,
   output logic             settle_done,
   output logic [TAPS-1:0]  status_bus
);
   localparam int unsigned CNT_W = EXP_TOP + 1 - EXP_OFFSET;

   if (EXP_OFFSET > 7) begin : g_bad_offset
      $error("EXP_OFFSET must leave the shortest threshold at least 2 clocks");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             clr;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] cnt_q;

   assign clr = stop_enter | osc_off | ~osc_started;

   osc_settle_count #(.EXP_OFFSET(EXP_OFFSET), .CNT_W(CNT_W)) u_count (
      .clk     (osc_clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .sel     (limit_sel),
      .cnt_nxt (cnt_nxt),
      .cnt_q   (cnt_q),
      .done_q  (settle_done)
   );

   osc_settle_thermo #(.EXP_OFFSET(EXP_OFFSET), .CNT_W(CNT_W)) u_thermo (
      .clk      (osc_clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .cnt_nxt  (cnt_nxt),
      .status_q (status_osc)
   );

   osc_settle_sync #(.W(TAPS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (bus_clk),
      .rst_n (rst_n),
      .d     (status_osc),
      .q     (status_bus)
   );

   AST_DONE_AGREES: assert property (@(posedge osc_clk) disable iff (!rst_n)
      settle_done |-> (status_osc != '0)); // R7
   AST_RESET_ZERO: assert property (@(posedge osc_clk)
      !rst_n |-> (status_osc == '0) && !settle_done); // R1
endmodule

// File: tb/osc_settle_status_test.sv
module osc_settle_status_test;
   logic       osc_clk = 0;
   logic       bus_clk = 0;
   logic       rst_n = 0;
   logic       stop_enter = 0;
   logic       osc_off = 0;
   logic       osc_started = 0;
   logic [2:0] limit_sel = 3'd7;
   logic [7:0] status_osc;
   logic       settle_done;
   logic [7:0] status_bus;

   int n_chk = 0;
   int n_fail = 0;
   int elapsed = 0;

   always #5 bus_clk = ~bus_clk;   // 100 MHz
   always #7 osc_clk = ~osc_clk;

   osc_settle_status #(.EXP_OFFSET(6), .SYNC_STAGES(2)) uut (
      .osc_clk, .bus_clk, .rst_n, .stop_enter, .osc_off, .osc_started,
      .limit_sel, .status_osc, .settle_done, .status_bus
   );

   // Thresholds with offset 6: exponents 2,3,4,5,7,9,11,12
   function automatic int thr(int idx);
      int e[8] = '{2, 3, 4, 5, 7, 9, 11, 12};
      return 1 << e[idx];
   endfunction

   function automatic logic [7:0] exp_status(int n, int sel);
      logic [7:0] r = '0;
      int ns = (n < thr(sel)) ? n : thr(sel);
      for (int i = 0; i < 8; i++) r[7-i] = (ns >= thr(i));
      return r;
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic advance(int k);
      repeat (k) @(posedge osc_clk);
      #2;
      elapsed += k;
   endtask

   task automatic restart(logic [2:0] sel);
      @(negedge osc_clk);
      limit_sel = sel;
      stop_enter = 1;
      @(posedge osc_clk); #2;
      check("R4 stop clears status", status_osc, 8'h00);
      check("R4 stop clears done", {7'b0, settle_done}, 8'h00);
      @(negedge osc_clk);
      stop_enter = 0;
      elapsed = 0;
   endtask

   task automatic t_reset();
      #3;
      check("R1 status in reset", status_osc, 8'h00);
      check("R1 bus in reset", status_bus, 8'h00);
      check("R1 done in reset", {7'b0, settle_done}, 8'h00);
      @(negedge osc_clk);
      rst_n = 1;
      osc_started = 1;
      elapsed = 0;
   endtask

   task automatic t_thresholds();
      restart(3'd7);
      for (int i = 0; i < 8; i++) begin
         advance(thr(i) - 1 - elapsed);
         check("R2 one edge before threshold", status_osc, exp_status(elapsed, 7));
         advance(1);
         check("R2 on threshold", status_osc, exp_status(elapsed, 7));
      end
      advance(30);
      check("R3 all ones held", status_osc, 8'hFF);
      repeat (4) @(posedge bus_clk);
      #2;
      check("R9 bus copy matches", status_bus, 8'hFF);
   endtask

   task automatic t_async_reset();
      @(negedge osc_clk);
      rst_n = 0;
      #2;
      check("R1 async reset clears now", status_osc, 8'h00);
      check("R1 async reset clears bus", status_bus, 8'h00);
      @(negedge osc_clk);
      rst_n = 1;
      elapsed = 0;
   endtask

   task automatic t_stop();
      restart(3'd7);
      advance(40);
      check("R2 mid count", status_osc, exp_status(40, 7));
      restart(3'd7);
      advance(3);
      check("R4 restart from zero", status_osc, 8'h00);
      advance(1);
      check("R4 first threshold after stop", status_osc, 8'h80);
   endtask

   task automatic t_off();
      restart(3'd7);
      advance(20);
      @(negedge osc_clk);
      osc_off = 1;
      advance(1);
      check("R5 off clears", status_osc, 8'h00);
      advance(50);
      check("R5 held zero while off", status_osc, 8'h00);
      @(negedge osc_clk);
      osc_off = 0;
      elapsed = 0;
      advance(3);
      check("R5 resume from zero", status_osc, 8'h00);
      advance(1);
      check("R5 first edge counts", status_osc, 8'h80);
   endtask

   task automatic t_not_started();
      @(negedge osc_clk);
      osc_started = 0;
      advance(60);
      check("R8 no count before start", status_osc, 8'h00);
      check("R8 no done before start", {7'b0, settle_done}, 8'h00);
      @(negedge osc_clk);
      osc_started = 1;
      elapsed = 0;
      advance(4);
      check("R8 count after start", status_osc, 8'h80);
   endtask

   task automatic t_limits();
      for (int s = 0; s < 8; s++) begin
         restart(3'(s));
         advance(thr(s) - 1);
         check("R7 done low before limit", {7'b0, settle_done}, 8'h00);
         advance(1);
         check("R7 done at limit", {7'b0, settle_done}, 8'h01);
         check("R6 status at limit", status_osc, exp_status(elapsed, s));
         advance(40);
         check("R6 no bits beyond limit", status_osc, exp_status(elapsed, s));
         check("R7 done stays", {7'b0, settle_done}, 8'h01);
         repeat (4) @(posedge bus_clk);
         #2;
         check("R9 bus follows limit", status_bus, exp_status(elapsed, s));
      end
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_thresholds();
      t_async_reset();
      t_stop();
      t_off();
      t_not_started();
      t_limits();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule